// File: doc/BRIEF.md
# Sensor Readout Timing Generator

This block sequences the readout of a progressive-scan pixel array. It counts pixel clocks into rows of a programmable length and counts rows into frames. From these counts it produces the row and column addresses of the pixel being read, a frame strobe, a line strobe and a pixel-valid qualifier. Every output is a plain function of registered state, so each one changes on a pixel clock edge and has no further delay.

The block is set up through a simple write port. Each register write first lands in a pending copy. Window, blanking, row-length and mirror values move from the pending copy into the active copy at the next frame wrap, on a restart command, or on an update command. The exposure value moves only on an update command. The frame lasts the window height plus the vertical blanking, or the exposure time if that is longer. The mirror flag reverses the order in which the window rows are read. A restart command abandons the current frame at once and begins a new one.

Top module: `rtg_readout_timing`

## Requirements
- R1: Register write port map, one register per address: 0 first column, 1 first row, 2 width, 3 height, 4 exposure (rows), 5 vertical blanking (rows), 6 row length (pixel clocks), 7 mirror (bit 0). Address 8 is the command register: bit 0 is restart and bit 1 is update. While reset is held, both strobes are low. In the first cycle after reset is released, the first row of a frame starts with the default window: row address 0x00E, column address 0x026, both strobes high.
- R2: In every active row, the line strobe is high for exactly width consecutive pixel clocks. During these clocks the column address runs from the first column up to first column + width - 1.
- R3: The frame strobe is high continuously for height × row-length clocks, starting at the first active row. The line strobe is never high while the frame strobe is low.
- R4: With mirror 0, the rows of a frame are addressed from first row up to first row + height - 1. The row address does not change while the line strobe is high.
- R5: With mirror 1, the rows of a frame are addressed from first row + height - 1 down to first row.
- R6: When exposure is less than height + blanking, the frame period is (height + blanking) × row length.
- R7: When exposure is greater than or equal to height + blanking, the frame period is exposure × row length. When exposure equals height + blanking, the period is the same as in R6.
- R8: A command write with bit 0 set drives both strobes low in the next cycle. In the cycle after that, a new frame starts at its first row and first column.
- R9: A window write made in the middle of a frame does not change the rest of that frame. It takes effect from the next frame.
- R10: A written exposure value is ignored across frame wraps and restarts. It takes effect only after a command write with bit 1 set.
- R11: A command write with only bit 1 set does not interrupt the frame that is running.
- R12: A restart that arrives in the same cycle as the natural end of a frame takes priority. Both strobes go low in the next cycle, and the new frame starts one cycle later.
- R13: The pixel-valid output is high exactly when the line strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (4) | Register address |
| cfg_wdata | input | TIME_W (16) | Register write data |
| frame_valid | output | 1 | High during the active rows of a frame |
| line_valid | output | 1 | High during the active pixels of a row |
| pix_valid | output | 1 | Pixel qualifier |
| row_addr | output | ADDR_W (10) | Array row being read, 0 outside active rows |
| col_addr | output | ADDR_W (10) | Array column being read, 0 outside active pixels |

## Verification
A restart command and the natural wrap at the last clock of a frame can both fall on the same clock edge. Both of them reset the counters and commit the pending window. Only the restart also blanks the strobes for one cycle. The bench aligns to a rise of the frame strobe, steps exactly to the last clock of the frame and issues the restart there. It then requires the strobes to be low for one cycle and then high again. A plain wrap at that edge would leave the frame strobe high.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   // Register map of the configuration write port
   localparam int FLD_COL0 = 0;
   localparam int FLD_ROW0 = 1;
   localparam int FLD_WID  = 2;
   localparam int FLD_HGT  = 3;
   localparam int FLD_EXP  = 4;
   localparam int FLD_VBL  = 5;
   localparam int FLD_RTM  = 6;
   localparam int FLD_MIR  = 7;
   localparam int NUM_FLD  = 8;
   localparam int CMD_ADDR = 8;

   // Command register bits
   localparam int CMD_RESTART_BIT = 0;
   localparam int CMD_UPDATE_BIT  = 1;

   typedef enum logic {
      ST_SETTLE = 1'b0,
      ST_RUN    = 1'b1
   } rtg_state_e;

endpackage

// File: rtl/rtg_field.sv
module rtg_field #(
   parameter int           W   = 10,
   parameter logic [W-1:0] DEF = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         commit,
   output logic [W-1:0] active
);

   logic [W-1:0] pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= DEF;
         active <= DEF;
      end else begin
         if (wr_en)  pend   <= wr_data;
         if (commit) active <= pend;
      end
   end

endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int                ADDR_W    = 10,
   parameter int                TIME_W    = 16,
   parameter int                AW        = 4,
   parameter bit                MIRROR_EN = 1'b1,
   parameter logic [ADDR_W-1:0] COL0_DEF  = 'h026,
   parameter logic [ADDR_W-1:0] ROW0_DEF  = 'h00E,
   parameter logic [ADDR_W-1:0] WID_DEF   = 'h2F0,
   parameter logic [ADDR_W-1:0] HGT_DEF   = 'h246,
   parameter logic [TIME_W-1:0] EXP_DEF   = 'h0032,
   parameter logic [TIME_W-1:0] VBL_DEF   = 'h0020,
   parameter logic [TIME_W-1:0] RTM_DEF   = 'h038C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [TIME_W-1:0] cfg_wdata,
   input  logic              frame_wrap,
   output logic              restart_cmd,
   output logic              update_cmd,
   output logic [ADDR_W-1:0] act_col0,
   output logic [ADDR_W-1:0] act_row0,
   output logic [ADDR_W-1:0] act_wid,
   output logic [ADDR_W-1:0] act_hgt,
   output logic [TIME_W-1:0] act_exp,
   output logic [TIME_W-1:0] act_vbl,
   output logic [TIME_W-1:0] act_rtm,
   output logic              act_mir
);

   logic [NUM_FLD-1:0] sel;
   logic               cmd_sel;
   logic               geom_commit;

   for (genvar i = 0; i < NUM_FLD; i++) begin : g_sel
      assign sel[i] = cfg_we && (cfg_addr == AW'(i));
   end

   assign cmd_sel     = cfg_we && (cfg_addr == AW'(CMD_ADDR));
   assign restart_cmd = cmd_sel && cfg_wdata[CMD_RESTART_BIT];
   assign update_cmd  = cmd_sel && cfg_wdata[CMD_UPDATE_BIT];
   assign geom_commit = frame_wrap || restart_cmd || update_cmd;

   rtg_field #(.W(ADDR_W), .DEF(COL0_DEF)) i_col0 (
      .clk(clk), .rst_n(rst_n), .wr_en(sel[FLD_COL0]),
      .wr_data(cfg_wdata[ADDR_W-1:0]), .commit(geom_commit), .active(act_col0));

   rtg_field #(.W(ADDR_W), .DEF(ROW0_DEF)) i_row0 (
      .clk(clk), .rst_n(rst_n), .wr_en(sel[FLD_ROW0]),
      .wr_data(cfg_wdata[ADDR_W-1:0]), .commit(geom_commit), .active(act_row0));

   rtg_field #(.W(ADDR_W), .DEF(WID_DEF)) i_wid (
      .clk(clk), .rst_n(rst_n), .wr_en(sel[FLD_WID]),
      .wr_data(cfg_wdata[ADDR_W-1:0]), .commit(geom_commit), .active(act_wid));

   rtg_field #(.W(ADDR_W), .DEF(HGT_DEF)) i_hgt (
      .clk(clk), .rst_n(rst_n), .wr_en(sel[FLD_HGT]),
      .wr_data(cfg_wdata[ADDR_W-1:0]), .commit(geom_commit), .active(act_hgt));

   // Exposure moves only on an explicit update command
   rtg_field #(.W(TIME_W), .DEF(EXP_DEF)) i_exp (
      .clk(clk), .rst_n(rst_n), .wr_en(sel[FLD_EXP]),
      .wr_data(cfg_wdata), .commit(update_cmd), .active(act_exp));

   rtg_field #(.W(TIME_W), .DEF(VBL_DEF)) i_vbl (
      .clk(clk), .rst_n(rst_n), .wr_en(sel[FLD_VBL]),
      .wr_data(cfg_wdata), .commit(geom_commit), .active(act_vbl));

   rtg_field #(.W(TIME_W), .DEF(RTM_DEF)) i_rtm (
      .clk(clk), .rst_n(rst_n), .wr_en(sel[FLD_RTM]),
      .wr_data(cfg_wdata), .commit(geom_commit), .active(act_rtm));

   if (MIRROR_EN) begin : g_mirror
      rtg_field #(.W(1), .DEF(1'b0)) i_mir (
         .clk(clk), .rst_n(rst_n), .wr_en(sel[FLD_MIR]),
         .wr_data(cfg_wdata[0]), .commit(geom_commit), .active(act_mir));
   end else begin : g_no_mirror
      assign act_mir = 1'b0;
   end

endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
   import rtg_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [ADDR_W-1:0] wid,
   input  logic [ADDR_W-1:0] hgt,
   input  logic [TIME_W-1:0] exp_rows,
   input  logic [TIME_W-1:0] vbl,
   input  logic [TIME_W-1:0] rtm,
   output logic              fv,
   output logic              lv,
   output logic              frame_wrap,
   output logic [ADDR_W-1:0] row_idx,
   output logic [ADDR_W-1:0] col_idx
);

   localparam int CNT_W = TIME_W + 1;

   rtg_state_e        state;
   logic [CNT_W-1:0]  row_cnt;
   logic [TIME_W-1:0] col_cnt;
   logic [CNT_W-1:0]  win_rows;
   logic [CNT_W-1:0]  exp_ext;
   logic [CNT_W-1:0]  frame_len;
   logic [CNT_W-1:0]  row_last;
   logic [TIME_W-1:0] col_last;
   logic              end_of_row;
   logic              end_of_frame;

   // Frame length: window plus blanking, stretched by a longer exposure
   assign win_rows  = CNT_W'(hgt) + CNT_W'(vbl);
   assign exp_ext   = CNT_W'(exp_rows);
   assign frame_len = (exp_ext < win_rows) ? win_rows : exp_ext;
   assign row_last  = (frame_len == '0) ? '0 : frame_len - 1'b1;
   assign col_last  = (rtm == '0) ? '0 : rtm - 1'b1;

   assign end_of_row   = (col_cnt >= col_last);
   assign end_of_frame = end_of_row && (row_cnt >= row_last);
   assign frame_wrap   = (state == ST_RUN) && end_of_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_SETTLE;
         row_cnt <= '0;
         col_cnt <= '0;
      end else if (restart) begin
         state   <= ST_SETTLE;
         row_cnt <= '0;
         col_cnt <= '0;
      end else begin
         unique case (state)
            ST_SETTLE: begin
               state   <= ST_RUN;
               row_cnt <= '0;
               col_cnt <= '0;
            end
            ST_RUN: begin
               if (end_of_row) begin
                  col_cnt <= '0;
                  row_cnt <= end_of_frame ? '0 : row_cnt + 1'b1;
               end else begin
                  col_cnt <= col_cnt + 1'b1;
               end
            end
            default: state <= ST_SETTLE;
         endcase
      end
   end

   assign fv      = (state == ST_RUN) && (row_cnt < CNT_W'(hgt));
   assign lv      = fv && (col_cnt < TIME_W'(wid));
   assign row_idx = row_cnt[ADDR_W-1:0];
   assign col_idx = col_cnt[ADDR_W-1:0];

endmodule

// File: rtl/rtg_addr.sv
module rtg_addr #(
   parameter int ADDR_W = 10
) (
   input  logic              fv,
   input  logic              lv,
   input  logic              mirror,
   input  logic [ADDR_W-1:0] col0,
   input  logic [ADDR_W-1:0] row0,
   input  logic [ADDR_W-1:0] hgt,
   input  logic [ADDR_W-1:0] row_idx,
   input  logic [ADDR_W-1:0] col_idx,
   output logic [ADDR_W-1:0] row_addr,
   output logic [ADDR_W-1:0] col_addr
);

   logic [ADDR_W-1:0] row_fwd;
   logic [ADDR_W-1:0] row_rev;

   assign row_fwd = row0 + row_idx;
   assign row_rev = row0 + hgt - ADDR_W'(1) - row_idx;

   always_comb begin
      row_addr = '0;
      col_addr = '0;
      if (fv) row_addr = mirror ? row_rev : row_fwd;
      if (lv) col_addr = col0 + col_idx;
   end

endmodule

// File: rtl/rtg_readout_timing.sv
module rtg_readout_timing #(
   parameter int                ADDR_W    = 10,
   parameter int                TIME_W    = 16,
   parameter int                AW        = 4,
   parameter bit                MIRROR_EN = 1'b1,
   parameter logic [ADDR_W-1:0] COL0_DEF  = 'h026,
   parameter logic [ADDR_W-1:0] ROW0_DEF  = 'h00E,
   parameter logic [ADDR_W-1:0] WID_DEF   = 'h2F0,
   parameter logic [ADDR_W-1:0] HGT_DEF   = 'h246,
   parameter logic [TIME_W-1:0] EXP_DEF   = 'h0032,
   parameter logic [TIME_W-1:0] VBL_DEF   = 'h0020,
   parameter logic [TIME_W-1:0] RTM_DEF   = 'h038C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [TIME_W-1:0] cfg_wdata,
   output logic              frame_valid,
   output logic              line_valid,
   output logic              pix_valid,
   output logic [ADDR_W-1:0] row_addr,
   output logic [ADDR_W-1:0] col_addr
);

   initial begin
      assert (TIME_W >= ADDR_W) else $error("TIME_W must cover ADDR_W");
      assert (AW >= 4) else $error("AW too small for the register map");
      assert (TIME_W >= 2) else $error("TIME_W too small for command bits");
   end

   logic              restart_cmd;
   logic              update_cmd;
   logic              frame_wrap;
   logic [ADDR_W-1:0] act_col0;
   logic [ADDR_W-1:0] act_row0;
   logic [ADDR_W-1:0] act_wid;
   logic [ADDR_W-1:0] act_hgt;
   logic [TIME_W-1:0] act_exp;
   logic [TIME_W-1:0] act_vbl;
   logic [TIME_W-1:0] act_rtm;
   logic              act_mir;
   logic [ADDR_W-1:0] row_idx;
   logic [ADDR_W-1:0] col_idx;

   rtg_regs #(
      .ADDR_W(ADDR_W), .TIME_W(TIME_W), .AW(AW), .MIRROR_EN(MIRROR_EN),
      .COL0_DEF(COL0_DEF), .ROW0_DEF(ROW0_DEF), .WID_DEF(WID_DEF),
      .HGT_DEF(HGT_DEF), .EXP_DEF(EXP_DEF), .VBL_DEF(VBL_DEF), .RTM_DEF(RTM_DEF)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .frame_wrap(frame_wrap),
      .restart_cmd(restart_cmd), .update_cmd(update_cmd),
      .act_col0(act_col0), .act_row0(act_row0), .act_wid(act_wid),
      .act_hgt(act_hgt), .act_exp(act_exp), .act_vbl(act_vbl),
      .act_rtm(act_rtm), .act_mir(act_mir)
   );

   rtg_counters #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart_cmd),
      .wid(act_wid), .hgt(act_hgt), .exp_rows(act_exp), .vbl(act_vbl),
      .rtm(act_rtm), .fv(frame_valid), .lv(line_valid),
      .frame_wrap(frame_wrap), .row_idx(row_idx), .col_idx(col_idx)
   );

   rtg_addr #(.ADDR_W(ADDR_W)) i_addr (
      .fv(frame_valid), .lv(line_valid), .mirror(act_mir),
      .col0(act_col0), .row0(act_row0), .hgt(act_hgt),
      .row_idx(row_idx), .col_idx(col_idx),
      .row_addr(row_addr), .col_addr(col_addr)
   );

   assign pix_valid = frame_valid && line_valid;

endmodule

// File: rtl/rtg_readout_timing_chk.sv
module rtg_readout_timing_chk #(
   parameter int ADDR_W = 10,
   parameter int AW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [AW-1:0]     cfg_addr,
   input logic              restart_bit,
   input logic              fv,
   input logic              lv,
   input logic [ADDR_W-1:0] row_addr,
   input logic [ADDR_W-1:0] col_addr
);

   logic restart_hit;
   assign restart_hit = cfg_we && (cfg_addr == AW'(rtg_pkg::CMD_ADDR)) && restart_bit;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!fv && !lv)); // R1

   AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (!rst_n)
      lv |-> fv); // R3

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (lv && $past(lv)) |-> (col_addr == $past(col_addr) + ADDR_W'(1))); // R2

   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lv && $past(lv)) |-> $stable(row_addr)); // R4

   AST_RESTART_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      restart_hit |=> (!fv && !lv)); // R8

endmodule

bind rtg_readout_timing rtg_readout_timing_chk #(.ADDR_W(ADDR_W), .AW(AW)) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .restart_bit(cfg_wdata[0]), .fv(frame_valid), .lv(line_valid),
   .row_addr(row_addr), .col_addr(col_addr)
);

// File: tb/test_rtg_readout_timing.sv
module test_rtg_readout_timing;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        frame_valid, line_valid, pix_valid;
   logic [9:0]  row_addr, col_addr;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   int c_period, c_fvhi, c_runs, c_runmin, c_runmax, c_pvbad, c_lvout, c_firstcol, c_lastcol;
   int c_rows [8];

   always #2 clk = ~clk;

   rtg_readout_timing i_rtg_readout_timing (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .frame_valid(frame_valid), .line_valid(line_valid),
      .pix_valid(pix_valid), .row_addr(row_addr), .col_addr(col_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      cfg_we    = 1'b1;
      cfg_addr  = 4'(addr);
      cfg_wdata = 16'(data);
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input int col0, input int row0, input int wid, input int hgt,
                        input int expo, input int vbl, input int rtm, input int mir);
      wr(0, col0); wr(1, row0); wr(2, wid); wr(3, hgt);
      wr(4, expo); wr(5, vbl); wr(6, rtm); wr(7, mir);
      wr(8, 3);
   endtask

   task automatic wait_rise();
      logic pfv;
      pfv = frame_valid;
      for (int g = 0; g < 5000; g++) begin
         @(negedge clk);
         if (frame_valid && !pfv) return;
         pfv = frame_valid;
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic capture();
      int   run;
      logic pfv;
      wait_rise();
      c_period = 0; c_fvhi = 0; c_runs = 0; c_runmin = 9999; c_runmax = 0;
      c_pvbad = 0; c_lvout = 0; c_firstcol = -1; c_lastcol = -1; run = 0;
      forever begin
         c_period++;
         if (frame_valid) c_fvhi++;
         if (line_valid && !frame_valid) c_lvout++;
         if (pix_valid != line_valid) c_pvbad++;
         if (line_valid) begin
            if (run == 0) begin
               if (c_runs < 8) c_rows[c_runs] = int'(row_addr);
               if (c_runs == 0) c_firstcol = int'(col_addr);
               c_runs++;
            end
            run++;
            c_lastcol = int'(col_addr);
         end else if (run != 0) begin
            if (run < c_runmin) c_runmin = run;
            if (run > c_runmax) c_runmax = run;
            run = 0;
         end
         pfv = frame_valid;
         @(negedge clk);
         if (frame_valid && !pfv) break;
         if (c_period > 5000) break;
      end
   endtask

   task automatic t_reset();
      step(3);
      chk(!frame_valid && !line_valid, "R1 strobes in reset", int'(frame_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(frame_valid && line_valid, "R1 first cycle strobes", int'(line_valid), 1);
      chk(row_addr == 10'h00E, "R1 default row", int'(row_addr), 14);
      chk(col_addr == 10'h026, "R1 default col", int'(col_addr), 38);
   endtask

   task automatic t_normal();
      setup(3, 10, 5, 3, 1, 2, 8, 0);
      capture();
      chk(c_period == 40, "R6 frame period", c_period, 40);
      chk(c_fvhi == 24, "R3 frame strobe length", c_fvhi, 24);
      chk(c_lvout == 0, "R3 line outside frame", c_lvout, 0);
      chk(c_runs == 3, "R2 line count", c_runs, 3);
      chk(c_runmin == 5 && c_runmax == 5, "R2 line length", c_runmax, 5);
      chk(c_firstcol == 3, "R2 first column", c_firstcol, 3);
      chk(c_lastcol == 7, "R2 last column", c_lastcol, 7);
      chk(c_rows[0] == 10, "R4 row 0", c_rows[0], 10);
      chk(c_rows[1] == 11, "R4 row 1", c_rows[1], 11);
      chk(c_rows[2] == 12, "R4 row 2", c_rows[2], 12);
      chk(c_pvbad == 0, "R13 pixel valid", c_pvbad, 0);
   endtask

   task automatic t_mirror();
      setup(3, 10, 5, 3, 1, 2, 8, 1);
      capture();
      chk(c_rows[0] == 12, "R5 row 0", c_rows[0], 12);
      chk(c_rows[1] == 11, "R5 row 1", c_rows[1], 11);
      chk(c_rows[2] == 10, "R5 row 2", c_rows[2], 10);
      chk(c_period == 40, "R5 frame period", c_period, 40);
   endtask

   task automatic t_exposure();
      setup(3, 10, 5, 3, 9, 2, 8, 0);
      capture();
      chk(c_period == 72, "R7 long exposure period", c_period, 72);
      chk(c_fvhi == 24, "R7 frame strobe length", c_fvhi, 24);
      setup(3, 10, 5, 3, 5, 2, 8, 0);
      capture();
      chk(c_period == 40, "R7 equal exposure period", c_period, 40);
      setup(3, 10, 5, 3, 4, 2, 8, 0);
      capture();
      chk(c_period == 40, "R6 short exposure period", c_period, 40);
   endtask

   task automatic t_pending_exp();
      wr(4, 12);
      capture();
      chk(c_period == 40, "R10 exposure held over wrap", c_period, 40);
      wr(8, 1);
      capture();
      chk(c_period == 40, "R10 exposure held over restart", c_period, 40);
      wr(8, 2);
      capture();
      chk(c_period == 96, "R10 exposure after update", c_period, 96);
   endtask

   task automatic t_pending_geom();
      int n;
      setup(3, 10, 5, 3, 1, 2, 8, 0);
      wait_rise();
      wr(2, 2);
      n = 0;
      for (int g = 0; g < 200; g++) begin
         if (!frame_valid) break;
         if (line_valid) n++;
         @(negedge clk);
      end
      chk(n == 14, "R9 current frame unchanged", n, 14);
      capture();
      chk(c_runmax == 2 && c_runmin == 2, "R9 next frame width", c_runmax, 2);
      chk(c_lastcol == 4, "R9 next frame last column", c_lastcol, 4);
   endtask

   task automatic t_restart();
      setup(3, 10, 5, 3, 1, 2, 8, 0);
      wait_rise();
      step(10);
      wr(8, 1);
      chk(!frame_valid && !line_valid, "R8 strobes low after restart", int'(frame_valid), 0);
      @(negedge clk);
      chk(frame_valid && line_valid, "R8 new frame starts", int'(line_valid), 1);
      chk(row_addr == 10 && col_addr == 3, "R8 new frame origin", int'(row_addr), 10);
   endtask

   task automatic t_restart_at_wrap();
      wait_rise();
      step(39);
      wr(8, 1);
      chk(!frame_valid && !line_valid, "R12 restart wins at wrap", int'(frame_valid), 0);
      @(negedge clk);
      chk(frame_valid && row_addr == 10, "R12 frame restarts", int'(row_addr), 10);
   endtask

   task automatic t_update_only();
      wait_rise();
      step(5);
      wr(8, 2);
      chk(frame_valid == 1'b1, "R11 frame continues", int'(frame_valid), 1);
      capture();
      chk(c_period == 40, "R11 period intact", c_period, 40);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_normal();
      t_mirror();
      t_exposure();
      t_pending_exp();
      t_pending_geom();
      t_restart();
      t_restart_at_wrap();
      t_update_only();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule